// File: doc/BRIEF.md
# Slow-Clock Latched Reset Controller

This block produces the internal system reset of a small controller clocked from a 32.768 kHz low-speed oscillator. Two sources can request a reset. One is an active-high reset pin. The other is a key chord: four port pins held high together, included when a build parameter enables it. Each request passes a sampled glitch filter. A chord must also stay held for a number of slow-tap ticks before it counts as a request. Any qualified request sets a latch. The latch keeps the system reset asserted after the request has gone away.

The latch can be cleared only while no request is present and the 16 Hz tap of the on-block binary divider is high. Release is therefore always aligned to that divider phase. The same divider also provides a 1 kHz tap and a slow (nominally 1 Hz) tap. The bits below and including the 16 Hz tap run freely at all times. The bits above it are held at zero while the reset is asserted, so release timing never stalls.

Top module: `lsclk_reset_ctrl`

## Requirements
- R1: While `por` is high, and from then until the first qualified release, `sys_rst` is 1. `por` also clears the divider, so all three taps read 0 during `por`.
- R2: The pin request passes the filter only after `FLT_N` consecutive samples taken on cycles with `smp_tick` = 1 all find it high (default 3). Cycles with `smp_tick` = 0 neither count nor clear. One low sample clears the count. A shorter pulse leaves `sys_rst` at 0.
- R3: Once the filtered pin request is high, `sys_rst` is 1 from the next cycle and stays 1 while the request holds.
- R4: `sys_rst` falls only one cycle after a cycle in which no filtered request is present and `tap_16hz` is 1. It falls at the first such cycle.
- R5: Suppose the pin is dropped in the first cycle that `tap_16hz` reads 0 after a high phase. Then `sys_rst` first reads 0 exactly 1025 cycles later: 1024 low cycles of the tap plus the filter register.
- R6: Each tap is one divider bit: `tap_1k` = bit `TAP_1K`, `tap_16hz` = bit `TAP_16`, `tap_1hz` = bit `TAP_1HZ`. So `tap_1k` holds each level for 2^`TAP_1K` cycles. While `sys_rst` is 1, the bits above `TAP_16` stay 0, so `tap_1hz` stays 0.
- R7: With the chord enabled, all four `key_pins` high, once filtered, set the reset after `KEY_TICKS` rising edges of `tap_1hz` (default 2). A chord that sees fewer edges causes no reset.
- R8: Any key pin going low clears the chord's tick count, so several short holds never add up to a reset.
- R9: A chord with fewer than four pins high has no effect on `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock (32.768 kHz nominal) |
| por | input | 1 | Synchronous power-on clear, active high; sets the latch |
| smp_tick | input | 1 | Sampling strobe for the glitch filters |
| rst_pin | input | 1 | External reset request, active high |
| key_pins | input | 4 | Port pins forming the reset chord |
| sys_rst | output | 1 | Internal system reset, active high |
| tap_1k | output | 1 | Divider tap, about 1 kHz |
| tap_16hz | output | 1 | Divider tap, 16 Hz; gates release |
| tap_1hz | output | 1 | Slow divider tap qualifying the chord |

## Verification
The bench keeps the default filter length of 3 and `TAP_16` = 10, so the full 1024-cycle low phase of the release tap and the exact worst-case latency are measured as built. It lowers `TAP_1HZ` to 12, which makes a slow tick every 8192 cycles. With that, chord qualification and its restart on a dropped pin fit in a short run. The bench also checks that the slow tap freezes while reset holds. The chord option is built enabled.

// File: rtl/rst_pkg.sv
package rst_pkg;

    localparam int KEY_W = 4;

    // qualified reset requests that feed the latch
    typedef struct packed {
        logic pin;
        logic key;
    } rst_req_t;

    function automatic logic chord_full(input logic [KEY_W-1:0] keys);
        return &keys;
    endfunction

    function automatic logic any_req(input rst_req_t r);
        return r.pin | r.key;
    endfunction

endpackage

// File: rtl/rst_divider.sv
module rst_divider #(
    parameter int TAP_1K  = 4,
    parameter int TAP_16  = 10,
    parameter int TAP_1HZ = 14
) (
    input  logic clk,
    input  logic por,
    input  logic hold_i,
    output logic tap_1k_o,
    output logic tap_16_o,
    output logic tap_slow_o,
    output logic tick_o
);
    localparam int CNT_W = TAP_1HZ + 1;
    localparam int LO_W  = TAP_16 + 1;
    localparam int HI_W  = CNT_W - LO_W;

    logic [LO_W-1:0]  lo_q;
    logic [HI_W-1:0]  hi_q;
    logic [CNT_W-1:0] full;
    logic             slow_d;

    assign full = {hi_q, lo_q};

    // low part runs freely so the release tap keeps toggling
    always_ff @(posedge clk) begin
        if (por) begin
            lo_q <= '0;
        end else begin
            lo_q <= lo_q + 1'b1;
        end
    end

    // high part is held at zero while reset is asserted
    always_ff @(posedge clk) begin
        if (por || hold_i) begin
            hi_q <= '0;
        end else if (&lo_q) begin
            hi_q <= hi_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            slow_d <= 1'b0;
        end else begin
            slow_d <= full[TAP_1HZ];
        end
    end

    assign tap_1k_o   = full[TAP_1K];
    assign tap_16_o   = full[TAP_16];
    assign tap_slow_o = full[TAP_1HZ];
    assign tick_o     = full[TAP_1HZ] & ~slow_d;

    // R6
    slow_frozen_chk: assert property (@(posedge clk) disable iff (por)
        $past(hold_i) |-> !tap_slow_o);

endmodule

// File: rtl/rst_glitch_filter.sv
module rst_glitch_filter #(
    parameter int FLT_N = 3
) (
    input  logic clk,
    input  logic por,
    input  logic smp_i,
    input  logic req_i,
    output logic flt_o
);
    localparam int CW = $clog2(FLT_N + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (por) begin
            run_q <= '0;
            flt_o <= 1'b0;
        end else if (smp_i) begin
            if (req_i) begin
                if (run_q != CW'(FLT_N)) begin
                    run_q <= run_q + 1'b1;
                end
                flt_o <= (run_q >= CW'(FLT_N - 1));
            end else begin
                run_q <= '0;
                flt_o <= 1'b0;
            end
        end
    end

    // R2
    rise_needs_sample_chk: assert property (@(posedge clk) disable iff (por)
        $rose(flt_o) |-> $past(req_i) && $past(smp_i));

    // R2
    low_sample_drops_chk: assert property (@(posedge clk) disable iff (por)
        (smp_i && !req_i) |=> !flt_o);

endmodule

// File: rtl/rst_key_qual.sv
module rst_key_qual #(
    parameter int KEY_TICKS = 2
) (
    input  logic clk,
    input  logic por,
    input  logic key_i,
    input  logic tick_i,
    output logic set_o
);
    localparam int KW = $clog2(KEY_TICKS + 1);

    logic [KW-1:0] ticks_q;

    always_ff @(posedge clk) begin
        if (por || !key_i) begin
            ticks_q <= '0;
        end else if (tick_i && ticks_q != KW'(KEY_TICKS)) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    assign set_o = (ticks_q == KW'(KEY_TICKS));

    // R7
    set_after_tick_chk: assert property (@(posedge clk) disable iff (por)
        $rose(set_o) |-> $past(key_i) && $past(tick_i));

    // R8
    drop_restarts_chk: assert property (@(posedge clk) disable iff (por)
        !key_i |=> !set_o);

endmodule

// File: rtl/rst_latch.sv
module rst_latch (
    input  logic clk,
    input  logic por,
    input  logic set_i,
    input  logic tap_i,
    output logic rst_o
);
    always_ff @(posedge clk) begin
        if (por) begin
            rst_o <= 1'b1;
        end else if (set_i) begin
            rst_o <= 1'b1;
        end else if (tap_i) begin
            rst_o <= 1'b0;
        end
    end

    // R4
    release_gate_chk: assert property (@(posedge clk) disable iff (por)
        $fell(rst_o) |-> $past(tap_i) && !$past(set_i));

    // R3
    set_holds_chk: assert property (@(posedge clk) disable iff (por)
        set_i |=> rst_o);

endmodule

// File: rtl/lsclk_reset_ctrl.sv
module lsclk_reset_ctrl
    import rst_pkg::*;
#(
    parameter int FLT_N     = 3,
    parameter int KEY_TICKS = 2,
    parameter bit KEY_EN    = 1'b1,
    parameter int TAP_1K    = 4,
    parameter int TAP_16    = 10,
    parameter int TAP_1HZ   = 14
) (
    input  logic             clk,
    input  logic             por,
    input  logic             smp_tick,
    input  logic             rst_pin,
    input  logic [KEY_W-1:0] key_pins,
    output logic             sys_rst,
    output logic             tap_1k,
    output logic             tap_16hz,
    output logic             tap_1hz
);
    rst_req_t req;
    logic     slow_tick;
    logic     rst_q;

    rst_divider #(
        .TAP_1K (TAP_1K),
        .TAP_16 (TAP_16),
        .TAP_1HZ(TAP_1HZ)
    ) u_div (
        .clk       (clk),
        .por       (por),
        .hold_i    (rst_q),
        .tap_1k_o  (tap_1k),
        .tap_16_o  (tap_16hz),
        .tap_slow_o(tap_1hz),
        .tick_o    (slow_tick)
    );

    rst_glitch_filter #(.FLT_N(FLT_N)) u_pin_flt (
        .clk  (clk),
        .por  (por),
        .smp_i(smp_tick),
        .req_i(rst_pin),
        .flt_o(req.pin)
    );

    generate
        if (KEY_EN) begin : g_chord
            logic chord_f;

            rst_glitch_filter #(.FLT_N(FLT_N)) u_key_flt (
                .clk  (clk),
                .por  (por),
                .smp_i(smp_tick),
                .req_i(chord_full(key_pins)),
                .flt_o(chord_f)
            );

            rst_key_qual #(.KEY_TICKS(KEY_TICKS)) u_qual (
                .clk   (clk),
                .por   (por),
                .key_i (chord_f),
                .tick_i(slow_tick),
                .set_o (req.key)
            );
        end else begin : g_no_chord
            assign req.key = 1'b0;
        end
    endgenerate

    rst_latch u_latch (
        .clk  (clk),
        .por  (por),
        .set_i(any_req(req)),
        .tap_i(tap_16hz),
        .rst_o(rst_q)
    );

    assign sys_rst = rst_q;

    // R1
    por_sets_chk: assert property (@(posedge clk)
        por |=> sys_rst);

endmodule

// File: tb/sim_lsclk_reset_ctrl.sv
`timescale 1ns/1ps
module sim_lsclk_reset_ctrl;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       smp_tick = 1'b1;
    logic       rst_pin = 1'b0;
    logic [3:0] key_pins = 4'b0000;
    logic       sys_rst, tap_1k, tap_16hz, tap_1hz;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lsclk_reset_ctrl #(.TAP_1HZ(12)) u0 (
        .clk(clk), .por(por), .smp_tick(smp_tick), .rst_pin(rst_pin),
        .key_pins(key_pins), .sys_rst(sys_rst), .tap_1k(tap_1k),
        .tap_16hz(tap_16hz), .tap_1hz(tap_1hz)
    );

    localparam int NV = 5;
    localparam int PW [NV] = '{1, 2, 3, 4, 7};
    localparam bit PX [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_low();
        for (int n = 0; n < 3000 && sys_rst; n++) @(negedge clk);
    endtask

    // request removed at the previous negedge; release must follow the
    // first cycle with tap_16hz high
    task automatic check_release(input string tag);
        @(negedge clk);
        for (int n = 0; n < 3000 && !tap_16hz; n++) @(negedge clk);
        chk(sys_rst == 1'b1, {tag, " held until tap high"}, sys_rst, 1);
        @(negedge clk);
        chk(sys_rst == 1'b0, {tag, " released after tap high"}, sys_rst, 0);
    endtask

    task automatic hold_keys(input logic [3:0] k, input int cyc, inout bit seen);
        key_pins = k;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            seen |= sys_rst;
        end
        key_pins = 4'b0000;
    endtask

    initial begin
        int cnt;
        bit seen;
        bit hi_seen;

        // R1: reset state under por
        repeat (3) @(negedge clk);
        chk(sys_rst == 1'b1, "R1 sys_rst during por", sys_rst, 1);
        chk({tap_1k, tap_16hz, tap_1hz} == 3'b000, "R1 taps cleared by por",
            {tap_1k, tap_16hz, tap_1hz}, 0);
        por = 1'b0;
        @(negedge clk);
        chk(sys_rst == 1'b1, "R1 sys_rst after por", sys_rst, 1);
        check_release("R4 power-up");

        // R2/R3: pulse-width vector table
        for (int v = 0; v < NV; v++) begin
            wait_low();
            repeat (3) @(negedge clk);
            seen = 1'b0;
            rst_pin = 1'b1;
            for (int i = 0; i < PW[v]; i++) begin
                @(negedge clk);
                seen |= sys_rst;
            end
            rst_pin = 1'b0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                seen |= sys_rst;
            end
            chk(seen == PX[v], $sformatf("R2 R3 pulse of %0d cycles", PW[v]), seen, PX[v]);
        end

        // R2: gaps in the sampling strobe neither count nor clear
        wait_low();
        repeat (3) @(negedge clk);
        seen = 1'b0;
        rst_pin = 1'b1;
        @(negedge clk); seen |= sys_rst; smp_tick = 1'b0;
        @(negedge clk); seen |= sys_rst; smp_tick = 1'b1;
        @(negedge clk); seen |= sys_rst; rst_pin = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            seen |= sys_rst;
        end
        chk(seen == 1'b0, "R2 two samples only", seen, 0);

        // R3/R6: long hold keeps reset and freezes the slow tap
        wait_low();
        rst_pin = 1'b1;
        repeat (10) @(negedge clk);
        hi_seen = 1'b0;
        seen = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            hi_seen |= tap_1hz;
            seen &= sys_rst;
        end
        chk(seen == 1'b1, "R3 reset held with request", seen, 1);
        chk(hi_seen == 1'b0, "R6 slow tap frozen in reset", hi_seen, 0);

        // R4: drop mid low phase, release on first high phase
        while (tap_16hz) @(negedge clk);
        repeat (100) @(negedge clk);
        rst_pin = 1'b0;
        check_release("R4 mid-phase drop");

        // R5: worst case, drop as the tap falls
        rst_pin = 1'b1;
        while (!tap_16hz) @(negedge clk);
        while (tap_16hz) @(negedge clk);
        rst_pin = 1'b0;
        cnt = 0;
        while (sys_rst && cnt < 3000) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 1025, "R5 worst-case release latency", cnt, 1025);

        // R6: 1 kHz tap holds each level 16 cycles
        while (tap_1k) @(negedge clk);
        while (!tap_1k) @(negedge clk);
        cnt = 0;
        while (tap_1k && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 16, "R6 tap_1k half period", cnt, 16);

        // R7/R8: three short chord holds separated by drops
        wait_low();
        seen = 1'b0;
        for (int s = 0; s < 3; s++) begin
            hold_keys(4'b1111, 7000, seen);
            repeat (10) begin
                @(negedge clk);
                seen |= sys_rst;
            end
        end
        chk(seen == 1'b0, "R8 short chord holds do not add up", seen, 0);

        // R9: three of four pins high
        seen = 1'b0;
        hold_keys(4'b0111, 20000, seen);
        chk(seen == 1'b0, "R9 partial chord ignored", seen, 0);

        // R7: full chord held long enough
        seen = 1'b0;
        hold_keys(4'b1111, 20000, seen);
        chk(seen == 1'b1, "R7 qualified chord sets reset", seen, 1);
        check_release("R4 after chord");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule